// File: doc/BRIEF.md
# Soft-Error Retry and Ending-Status Accumulator

This block supervises the ending of one command block at a time, and of chains of them, for a storage attachment. For each command block it takes the soft-error-enable setting, a chain-start and a chain-end marker, and the attention condition. After each attempt the operation engine reports error flags. These are split into two groups. The four storage-side errors can be retried: storage parity, storage address out of range, key protection, and interface parity. The other three errors end the block at once: extra status available, late command reject, and block specification error.

When the first attempt fails with a retryable error and soft-error handling is enabled, the block asks for exactly one retry. It then decides the outcome. A failure gives a hard exception. Success gives a device end, and a success reached through the retry sets a permissive-device-end flag that stays set for the rest of the chain. At the end the block produces the ending condition code, the information byte, the status byte and the residual flag word. It also says whether the residual block may be written to memory. The memory writes and the operation engine itself sit outside the block.

Top module: `retry_status_acc`

## Requirements
- R1: A retry is requested (`retry_o` high for one cycle, the cycle after the attempt end is sampled) only when the block's soft-error enable is 1, the first attempt reports at least one retryable error and no non-retryable error; at most one retry is made per command block, with the count cleared at each block start.
- R2: With soft-error enable 0, or with any non-retryable error present, no retry is requested and the block ends at once with an exception.
- R3: An exception ends with `cc_o`=2, or 6 when attention was given at block start. `iib_o` is 0. `isb_o` holds the errors of the last attempt: bit 0 extra status, bit 1 late reject, bit 2 always 0, bit 3 specification error, bit 4 storage parity, bit 5 address out of range, bit 6 protection, bit 7 interface parity.
- R4: A successful end gives `cc_o`=3, or 7 with attention, and `isb_o`=0.
- R5: `iib_o` bit 0 is the permissive-device-end flag. It is set by any block of the current chain that succeeded on its retry, and cleared when a block starts with `chain_first_i`=1. Bits 7..1 are always 0.
- R6: `rsb_store_o` is 1 with `done_o` exactly when the block's soft-error enable is 1 and it did not end in an exception.
- R7: The residual flag word `rsf_o` is laid out as follows: bit 0 is the chain-end marker given at block start, bit 1 shows that a retry was made, bit 15 is 1 when there is no exception, and all other bits are 0.
- R8: `done_o` is a one-cycle pulse in the cycle after the final attempt end is sampled. An attempt end seen while idle is ignored, and a block start seen while busy is ignored.
- R9: After reset all outputs are 0 and the permissive-device-end flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Start of a command block (accepted while idle) |
| chain_first_i | input | 1 | Block opens a new chain |
| chain_last_i | input | 1 | Block is the last in its chain |
| se_i | input | 1 | Soft-error enable of the block |
| attn_i | input | 1 | Attention present for the ending |
| op_done_i | input | 1 | End of one attempt |
| rt_err_i | input | 4 | Retryable errors {iface parity, protect, bad address, storage parity} |
| nr_err_i | input | 3 | Non-retryable errors {spec error, late reject, extra status} |
| retry_o | output | 1 | Retry request pulse |
| done_o | output | 1 | Block ending pulse |
| cc_o | output | 3 | Ending condition code |
| iib_o | output | 8 | Information byte |
| isb_o | output | 8 | Status byte |
| rsf_o | output | 16 | Residual flag word |
| rsb_store_o | output | 1 | Residual block may be stored |

## Verification
The bench builds the block with the default retry limit of 1. With that limit, a block that fails twice reaches the hard-exception path, and a block that fails once and then succeeds sets the sticky permissive flag. Chains of two and three blocks show that the flag carries across blocks and clears when a new chain opens. Mixed flag patterns show how retryable and non-retryable errors combine in the status byte.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int unsigned RT_W  = 4;
  localparam int unsigned NR_W  = 3;
  localparam int unsigned SB_W  = 8;
  localparam int unsigned RSF_W = 16;

  localparam logic [2:0] CC_EXC      = 3'd2;
  localparam logic [2:0] CC_DEV_END  = 3'd3;
  localparam logic [2:0] CC_ATTN_EXC = 3'd6;
  localparam logic [2:0] CC_ATTN_END = 3'd7;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;
endpackage

// File: rtl/rsa_err_map.sv
module rsa_err_map
  import rsa_pkg::*;
(
  input  logic [RT_W-1:0] rt_err_i,
  input  logic [NR_W-1:0] nr_err_i,
  output logic [SB_W-1:0] isb_bits_o,
  output logic            any_rt_o,
  output logic            any_nr_o
);
  // status byte: [7:4] retryable, [3] spec, [2] zero, [1] reject, [0] extra status
  always_comb begin
    isb_bits_o = '0;
    for (int i = 0; i < RT_W; i++) isb_bits_o[4+i] = rt_err_i[i];
    isb_bits_o[0] = nr_err_i[0];
    isb_bits_o[1] = nr_err_i[1];
    isb_bits_o[3] = nr_err_i[2];
  end

  assign any_rt_o = |rt_err_i;
  assign any_nr_o = |nr_err_i;
endmodule

// File: rtl/rsa_seq.sv
module rsa_seq
  import rsa_pkg::*;
#(
  parameter int unsigned RETRY_LIMIT = 1,
  localparam int unsigned CNT_W = $clog2(RETRY_LIMIT + 1) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_start_i,
  input  logic chain_first_i,
  input  logic chain_last_i,
  input  logic se_i,
  input  logic attn_i,
  input  logic op_done_i,
  input  logic any_rt_i,
  input  logic any_nr_i,
  output logic retry_o,
  output logic fin_o,
  output logic fin_exc_o,
  output logic retried_o,
  output logic pde_next_o,
  output logic se_q_o,
  output logic last_q_o,
  output logic attn_q_o
);
  seq_st_e          st_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             pde_q, se_q, last_q, attn_q, retry_q;
  logic             accept, att_end, can_retry, do_retry;

  assign accept    = (st_q == ST_IDLE) && op_start_i;
  assign att_end   = (st_q == ST_BUSY) && op_done_i;
  assign can_retry = se_q && any_rt_i && !any_nr_i && (rcnt_q < CNT_W'(RETRY_LIMIT));
  assign do_retry  = att_end && can_retry;
  assign fin_o     = att_end && !can_retry;
  assign fin_exc_o = any_rt_i || any_nr_i;
  assign retried_o = (rcnt_q != '0);
  assign pde_next_o = pde_q | (!fin_exc_o && retried_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rcnt_q  <= '0;
      pde_q   <= 1'b0;
      se_q    <= 1'b0;
      last_q  <= 1'b0;
      attn_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      retry_q <= do_retry;
      if (accept) begin
        st_q   <= ST_BUSY;
        rcnt_q <= '0;
        se_q   <= se_i;
        last_q <= chain_last_i;
        attn_q <= attn_i;
        if (chain_first_i) pde_q <= 1'b0;
      end else if (do_retry) begin
        rcnt_q <= rcnt_q + 1'b1;
      end else if (fin_o) begin
        st_q  <= ST_IDLE;
        pde_q <= pde_next_o;
      end
    end
  end

  assign retry_o  = retry_q;
  assign se_q_o   = se_q;
  assign last_q_o = last_q;
  assign attn_q_o = attn_q;

  p_retry_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcnt_q <= CNT_W'(RETRY_LIMIT));
  p_retry_after_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(op_done_i) && se_q);
  p_no_retry_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> !retry_o);
endmodule

// File: rtl/rsa_out.sv
module rsa_out
  import rsa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fin_i,
  input  logic             fin_exc_i,
  input  logic             retried_i,
  input  logic             pde_next_i,
  input  logic             se_q_i,
  input  logic             last_q_i,
  input  logic             attn_q_i,
  input  logic [SB_W-1:0]  isb_bits_i,
  output logic             done_o,
  output logic [2:0]       cc_o,
  output logic [SB_W-1:0]  iib_o,
  output logic [SB_W-1:0]  isb_o,
  output logic [RSF_W-1:0] rsf_o,
  output logic             rsb_store_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      cc_o        <= '0;
      iib_o       <= '0;
      isb_o       <= '0;
      rsf_o       <= '0;
      rsb_store_o <= 1'b0;
    end else begin
      done_o      <= fin_i;
      rsb_store_o <= fin_i && se_q_i && !fin_exc_i;
      if (fin_i) begin
        if (fin_exc_i) begin
          cc_o  <= attn_q_i ? CC_ATTN_EXC : CC_EXC;
          iib_o <= '0;
          isb_o <= isb_bits_i;
        end else begin
          cc_o  <= attn_q_i ? CC_ATTN_END : CC_DEV_END;
          iib_o <= {{(SB_W-1){1'b0}}, pde_next_i};
          isb_o <= '0;
        end
        rsf_o <= '0;
        rsf_o[0]       <= last_q_i;
        rsf_o[1]       <= retried_i;
        rsf_o[RSF_W-1] <= !fin_exc_i;
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_store_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsb_store_o |-> done_o && rsf_o[RSF_W-1]);
  p_exc_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o[1:0] == 2'b10) |-> (isb_o != '0) && !isb_o[2]);
  p_iib_high_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> iib_o[SB_W-1:1] == '0);
endmodule

// File: rtl/retry_status_acc.sv
module retry_status_acc
  import rsa_pkg::*;
#(
  parameter int unsigned RETRY_LIMIT = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        op_start_i,
  input  logic        chain_first_i,
  input  logic        chain_last_i,
  input  logic        se_i,
  input  logic        attn_i,
  input  logic        op_done_i,
  input  logic [3:0]  rt_err_i,
  input  logic [2:0]  nr_err_i,
  output logic        retry_o,
  output logic        done_o,
  output logic [2:0]  cc_o,
  output logic [7:0]  iib_o,
  output logic [7:0]  isb_o,
  output logic [15:0] rsf_o,
  output logic        rsb_store_o
);
  logic [SB_W-1:0] isb_bits;
  logic any_rt, any_nr, fin, fin_exc, retried, pde_next, se_q, last_q, attn_q;

  rsa_err_map u_map (
    .rt_err_i   (rt_err_i),
    .nr_err_i   (nr_err_i),
    .isb_bits_o (isb_bits),
    .any_rt_o   (any_rt),
    .any_nr_o   (any_nr)
  );

  rsa_seq #(.RETRY_LIMIT(RETRY_LIMIT)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_start_i    (op_start_i),
    .chain_first_i (chain_first_i),
    .chain_last_i  (chain_last_i),
    .se_i          (se_i),
    .attn_i        (attn_i),
    .op_done_i     (op_done_i),
    .any_rt_i      (any_rt),
    .any_nr_i      (any_nr),
    .retry_o       (retry_o),
    .fin_o         (fin),
    .fin_exc_o     (fin_exc),
    .retried_o     (retried),
    .pde_next_o    (pde_next),
    .se_q_o        (se_q),
    .last_q_o      (last_q),
    .attn_q_o      (attn_q)
  );

  rsa_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fin_i       (fin),
    .fin_exc_i   (fin_exc),
    .retried_i   (retried),
    .pde_next_i  (pde_next),
    .se_q_i      (se_q),
    .last_q_i    (last_q),
    .attn_q_i    (attn_q),
    .isb_bits_i  (isb_bits),
    .done_o      (done_o),
    .cc_o        (cc_o),
    .iib_o       (iib_o),
    .isb_o       (isb_o),
    .rsf_o       (rsf_o),
    .rsb_store_o (rsb_store_o)
  );
endmodule

// File: tb/retry_status_acc_tb.sv
module retry_status_acc_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic op_start_i = 0, chain_first_i = 0, chain_last_i = 0, se_i = 0, attn_i = 0, op_done_i = 0;
  logic [3:0] rt_err_i = '0;
  logic [2:0] nr_err_i = '0;
  logic retry_o, done_o, rsb_store_o;
  logic [2:0] cc_o;
  logic [7:0] iib_o, isb_o;
  logic [15:0] rsf_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit pde_m = 0;

  typedef struct packed {
    logic [2:0] cc; logic [7:0] iib; logic [7:0] isb; logic [15:0] rsf; logic st;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  retry_status_acc u_dut (.*, .clk_i(clk));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] map_isb(logic [3:0] rt, logic [2:0] nr);
    return {rt, nr[2], 1'b0, nr[1], nr[0]};
  endfunction

  // monitor: compare every ending against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      if (q.size() == 0) begin
        chk("R8 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R3/R4 cc", 32'(cc_o), 32'(e.cc));
        chk("R5 iib", 32'(iib_o), 32'(e.iib));
        chk("R3 isb", 32'(isb_o), 32'(e.isb));
        chk("R7 rsf", 32'(rsf_o), 32'(e.rsf));
        chk("R6 store", 32'(rsb_store_o), 32'(e.st));
      end
    end
  end

  task automatic run_dcb(input bit first, input bit last, input bit se, input bit attn,
                         input logic [3:0] rt1, input logic [2:0] nr1,
                         input logic [3:0] rt2, input logic [2:0] nr2);
    bit rty, exc;
    logic [3:0] rtf; logic [2:0] nrf;
    exp_t e;
    rty = se && (rt1 != 0) && (nr1 == 0);
    rtf = rty ? rt2 : rt1;
    nrf = rty ? nr2 : nr1;
    exc = (rtf != 0) || (nrf != 0);
    if (first) pde_m = 0;
    if (!exc && rty) pde_m = 1;
    e.cc  = exc ? (attn ? 3'd6 : 3'd2) : (attn ? 3'd7 : 3'd3);
    e.iib = exc ? 8'h00 : {7'b0, pde_m};
    e.isb = exc ? map_isb(rtf, nrf) : 8'h00;
    e.rsf = {!exc, 13'b0, rty, last};
    e.st  = se && !exc;
    q.push_back(e);

    op_start_i = 1; chain_first_i = first; chain_last_i = last; se_i = se; attn_i = attn;
    @(negedge clk);
    op_start_i = 0;
    op_done_i = 1; rt_err_i = rt1; nr_err_i = nr1;
    @(negedge clk);
    op_done_i = 0; rt_err_i = '0; nr_err_i = '0;
    chk(rty ? "R1 retry requested" : "R2 no retry", 32'(retry_o), 32'(rty));
    if (rty) begin
      op_done_i = 1; rt_err_i = rt2; nr_err_i = nr2;
      @(negedge clk);
      op_done_i = 0; rt_err_i = '0; nr_err_i = '0;
      chk("R1 single retry", 32'(retry_o), 32'd0);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 done", 32'(done_o), 0);
    chk("R9 retry", 32'(retry_o), 0);
    chk("R9 outs", {cc_o, iib_o, isb_o, rsb_store_o}, 0);
    chk("R9 rsf", 32'(rsf_o), 0);
    rst_ni = 1;
    @(negedge clk);

    run_dcb(1, 1, 0, 0, 4'h0, 3'h0, 4'h0, 3'h0);   // R4 clean, SE off
    run_dcb(1, 1, 1, 0, 4'h0, 3'h0, 4'h0, 3'h0);   // R6 clean, SE on
    run_dcb(1, 1, 1, 0, 4'h1, 3'h0, 4'h0, 3'h0);   // R1 retry succeeds, R5 pde
    run_dcb(1, 1, 0, 0, 4'h4, 3'h0, 4'h0, 3'h0);   // R2 protect, SE off
    run_dcb(1, 1, 1, 1, 4'h8, 3'h0, 4'h8, 3'h0);   // R3 fails twice with attention
    run_dcb(1, 1, 1, 0, 4'h3, 3'h0, 4'h2, 3'h0);   // R3 last-attempt bits
    run_dcb(1, 1, 1, 0, 4'h1, 3'h4, 4'h0, 3'h0);   // R2 non-retryable blocks retry
    run_dcb(1, 1, 0, 1, 4'h0, 3'h0, 4'h0, 3'h0);   // R4 attention device end
    run_dcb(1, 1, 1, 0, 4'h0, 3'h3, 4'h0, 3'h0);   // R3 reject + extra status
    // R5 chain: flag carries, then clears on new chain
    run_dcb(1, 0, 1, 0, 4'h2, 3'h0, 4'h0, 3'h0);
    run_dcb(0, 0, 0, 0, 4'h0, 3'h0, 4'h0, 3'h0);
    run_dcb(0, 1, 1, 0, 4'h0, 3'h0, 4'h0, 3'h0);
    run_dcb(1, 1, 0, 0, 4'h0, 3'h0, 4'h0, 3'h0);

    // R8 attempt end while idle is ignored
    op_done_i = 1; rt_err_i = 4'hF;
    @(negedge clk);
    op_done_i = 0; rt_err_i = '0;
    chk("R8 idle done ignored", {30'b0, done_o, retry_o}, 0);
    @(negedge clk);
    chk("R8 idle done ignored late", 32'(done_o), 0);

    // R8 start while busy is ignored: second start must not change attention or chain-end
    q.push_back('{cc: 3'd3, iib: 8'h00, isb: 8'h00, rsf: 16'h8000, st: 1'b0});
    op_start_i = 1; chain_first_i = 1; chain_last_i = 0; se_i = 0; attn_i = 0;
    @(negedge clk);
    chain_last_i = 1; attn_i = 1; se_i = 1;
    @(negedge clk);
    op_start_i = 0;
    op_done_i = 1;
    @(negedge clk);
    op_done_i = 0;
    repeat (3) @(negedge clk);

    chk("R8 scoreboard drained", 32'(q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule